// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between a narrow port (A) and a wide port made of two narrow lanes (lane 1 and lane 2). In the narrow-to-wide direction, two consecutive A words are gathered and presented together on the two lanes. Lane 1 sits behind a two-stage pipeline and lane 2 behind a single register. With the right enable sequence, the first word and the second word therefore leave on the same clock edge.

In the wide-to-narrow direction, each lane input has its own holding register. A registered select picks which stored lane drives A. Every register captures on the rising clock edge, and only while its own active-low capture enable is low.

The two active-low output enables are registered into a small drive-state machine with four states: DRV_NONE, DRV_B_ONLY, DRV_A_ONLY and DRV_BOTH. On every edge the machine moves to the state named by the enable pair just sampled, so any state can reach any other state in one transition. A tri-state pin is modeled as a data bus plus a drive flag, and the flag is high when the port drives.

An optional synchronous reset, active high, clears every data register and puts the machine in DRV_NONE.

Top module: `bus_exchanger_n2w`

## Requirements
- R1: While `rst` is high at a rising edge, all data registers clear to zero and the drive state becomes DRV_NONE. After that edge, `a_out`, `b1_out` and `b2_out` read 0, and `a_drive`, `b1_drive` and `b2_drive` read 0.
- R2: Lane 1 is fed by two register stages, and both stages advance on an edge where `a_cap1_n` is 0. A word on `a_in` at such an edge appears on `b1_out` after the second such edge.
- R3: On an edge where `a_cap2_n` is 0, `a_in` is captured into the lane 2 register and appears on `b2_out` after that edge.
- R4: Present word W0 with `a_cap1_n`=0 and `a_cap2_n`=1, then on the next edge present word W1 with both enables 0. After that second edge, `b1_out`=W0 and `b2_out`=W1.
- R5: While `a_cap1_n` is 1, `b1_out` is unchanged across the edge. While `a_cap2_n` is 1, `b2_out` is unchanged across the edge. Changes on `a_in` have no effect in either case.
- R6: On an edge where `b1_cap_n` is 0, `b1_in` is stored; on an edge where `b2_cap_n` is 0, `b2_in` is stored. A store whose enable is 1 keeps its old value.
- R7: `sel_lane1` is registered on every edge. A registered value of 1 routes the stored lane 1 word to `a_out`, and 0 routes the stored lane 2 word. A change on `sel_lane1` reaches `a_out` only after the next edge.
- R8: `a_drive` equals the inverse of `oe_a_n` as sampled on the previous edge. A low enable therefore drives A one edge later, and a high enable releases it one edge later.
- R9: `b1_drive` and `b2_drive` both equal the inverse of `oe_b_n` as sampled on the previous edge. All four enable pairs are legal, including both ports driving at once (DRV_BOTH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high (used when USE_RESET=1) |
| a_in | input | W | Narrow port input word |
| a_cap1_n | input | 1 | Active-low capture enable for both lane 1 pipeline stages |
| a_cap2_n | input | 1 | Active-low capture enable for the lane 2 register |
| b1_in | input | W | Lane 1 input word |
| b2_in | input | W | Lane 2 input word |
| b1_cap_n | input | 1 | Active-low capture enable for the lane 1 store |
| b2_cap_n | input | 1 | Active-low capture enable for the lane 2 store |
| sel_lane1 | input | 1 | Lane select: 1 picks lane 1, 0 picks lane 2 (registered) |
| oe_a_n | input | 1 | Active-low output enable for A (registered) |
| oe_b_n | input | 1 | Active-low output enable for both lanes (registered) |
| a_out | output | W | Narrow port output word |
| a_drive | output | 1 | A port drive flag |
| b1_out | output | W | Lane 1 output word |
| b1_drive | output | 1 | Lane 1 drive flag |
| b2_out | output | W | Lane 2 output word |
| b2_drive | output | 1 | Lane 2 drive flag |

## Verification
Each result is due a fixed number of edges after its stimulus:
- `b2_out`, `a_out`, the selection and all three drive flags follow one edge after the inputs are sampled.
- `b1_out` follows two enabled edges after the word enters lane 1.

The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares every output at the next falling edge, so each prediction is checked in the cycle the model says it lands. Directed sequences place the pairing and select checks on exactly the second and the first edge respectively.

// File: rtl/bx_pkg.sv
package bx_pkg;
    // bit 1: A port drives, bit 0: B lanes drive
    typedef enum logic [1:0] {
        DRV_NONE   = 2'b00,
        DRV_B_ONLY = 2'b01,
        DRV_A_ONLY = 2'b10,
        DRV_BOTH   = 2'b11
    } drive_state_t;
endpackage

// File: rtl/bx_drive_fsm.sv
module bx_drive_fsm #(
    parameter bit USE_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic oe_a_n,
    input  logic oe_b_n,
    output logic a_drive,
    output logic b_drive
);
    import bx_pkg::*;

    drive_state_t state_q;
    drive_state_t state_d;

    // next state: the enable pair just sampled names the target state
    always_comb begin
        unique case ({oe_a_n, oe_b_n})
            2'b11:   state_d = DRV_NONE;
            2'b10:   state_d = DRV_B_ONLY;
            2'b01:   state_d = DRV_A_ONLY;
            default: state_d = DRV_BOTH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (USE_RESET && rst) state_q <= DRV_NONE;
        else                  state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            DRV_NONE:   begin a_drive = 1'b0; b_drive = 1'b0; end
            DRV_B_ONLY: begin a_drive = 1'b0; b_drive = 1'b1; end
            DRV_A_ONLY: begin a_drive = 1'b1; b_drive = 1'b0; end
            default:    begin a_drive = 1'b1; b_drive = 1'b1; end
        endcase
    end

    a_r8_a_one_edge: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> a_drive == !$past(oe_a_n));
    a_r9_b_one_edge: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> b_drive == !$past(oe_b_n));
endmodule

// File: rtl/bx_a2b_path.sv
module bx_a2b_path #(
    parameter int W            = 12,
    parameter int LANE1_STAGES = 2,
    parameter bit USE_RESET    = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic         cap1_n,
    input  logic         cap2_n,
    output logic [W-1:0] lane1_out,
    output logic [W-1:0] lane2_out
);
    localparam int LAST = LANE1_STAGES - 1;

    logic [W-1:0] pipe_q [LANE1_STAGES];
    logic [W-1:0] lane2_q;

    for (genvar s = 0; s < LANE1_STAGES; s++) begin : g_stage
        logic [W-1:0] stage_in;
        if (s == 0) begin : g_head
            assign stage_in = a_in;
        end else begin : g_tail
            assign stage_in = pipe_q[s-1];
        end
        always_ff @(posedge clk) begin
            if (USE_RESET && rst) pipe_q[s] <= '0;
            else if (!cap1_n)     pipe_q[s] <= stage_in;
        end
    end

    always_ff @(posedge clk) begin
        if (USE_RESET && rst) lane2_q <= '0;
        else if (!cap2_n)     lane2_q <= a_in;
    end

    assign lane1_out = pipe_q[LAST];
    assign lane2_out = lane2_q;

    if (LANE1_STAGES == 2) begin : g_chk2
        a_r2_two_edges: assert property (@(posedge clk) disable iff (rst)
            (!cap1_n ##1 !cap1_n) |=> lane1_out == $past(a_in, 2));
    end
    a_r3_one_edge: assert property (@(posedge clk) disable iff (rst)
        !cap2_n |=> lane2_out == $past(a_in));
    a_r5_lane1_hold: assert property (@(posedge clk) disable iff (rst)
        cap1_n |=> $stable(lane1_out));
    a_r5_lane2_hold: assert property (@(posedge clk) disable iff (rst)
        cap2_n |=> $stable(lane2_out));
endmodule

// File: rtl/bx_b2a_path.sv
module bx_b2a_path #(
    parameter int W         = 12,
    parameter bit USE_RESET = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] l1_in,
    input  logic [W-1:0] l2_in,
    input  logic         l1_cap_n,
    input  logic         l2_cap_n,
    input  logic         sel_lane1,
    output logic [W-1:0] a_out
);
    logic [W-1:0] l1_q;
    logic [W-1:0] l2_q;
    logic         sel_q;

    always_ff @(posedge clk) begin
        if (USE_RESET && rst) begin
            l1_q  <= '0;
            l2_q  <= '0;
            sel_q <= 1'b0;
        end else begin
            if (!l1_cap_n) l1_q <= l1_in;
            if (!l2_cap_n) l2_q <= l2_in;
            sel_q <= sel_lane1;
        end
    end

    assign a_out = sel_q ? l1_q : l2_q;

    a_r7_pick_lane1: assert property (@(posedge clk) disable iff (rst)
        (!l1_cap_n && sel_lane1) |=> a_out == $past(l1_in));
    a_r7_pick_lane2: assert property (@(posedge clk) disable iff (rst)
        (!l2_cap_n && !sel_lane1) |=> a_out == $past(l2_in));
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (l1_cap_n && l2_cap_n && (sel_lane1 == sel_q)) |=> $stable(a_out));
endmodule

// File: rtl/bus_exchanger_n2w.sv
module bus_exchanger_n2w #(
    parameter int W            = 12,
    parameter int LANE1_STAGES = 2,
    parameter bit USE_RESET    = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic         a_cap1_n,
    input  logic         a_cap2_n,
    input  logic [W-1:0] b1_in,
    input  logic [W-1:0] b2_in,
    input  logic         b1_cap_n,
    input  logic         b2_cap_n,
    input  logic         sel_lane1,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    output logic [W-1:0] b1_out,
    output logic         b1_drive,
    output logic [W-1:0] b2_out,
    output logic         b2_drive
);
    logic b_drive;

    bx_a2b_path #(.W(W), .LANE1_STAGES(LANE1_STAGES), .USE_RESET(USE_RESET)) u_a2b (
        .clk       (clk),
        .rst       (rst),
        .a_in      (a_in),
        .cap1_n    (a_cap1_n),
        .cap2_n    (a_cap2_n),
        .lane1_out (b1_out),
        .lane2_out (b2_out)
    );

    bx_b2a_path #(.W(W), .USE_RESET(USE_RESET)) u_b2a (
        .clk       (clk),
        .rst       (rst),
        .l1_in     (b1_in),
        .l2_in     (b2_in),
        .l1_cap_n  (b1_cap_n),
        .l2_cap_n  (b2_cap_n),
        .sel_lane1 (sel_lane1),
        .a_out     (a_out)
    );

    bx_drive_fsm #(.USE_RESET(USE_RESET)) u_drv (
        .clk     (clk),
        .rst     (rst),
        .oe_a_n  (oe_a_n),
        .oe_b_n  (oe_b_n),
        .a_drive (a_drive),
        .b_drive (b_drive)
    );

    assign b1_drive = b_drive;
    assign b2_drive = b_drive;

    a_r1_reset_quiet: assert property (@(posedge clk)
        (USE_RESET && rst) |=> (!a_drive && !b1_drive && !b2_drive && b1_out == '0 && b2_out == '0));
endmodule

// File: tb/test_bus_exchanger_n2w.sv
`timescale 1ns/1ps
module test_bus_exchanger_n2w;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         a_cap1_n = 1'b1, a_cap2_n = 1'b1, b1_cap_n = 1'b1, b2_cap_n = 1'b1;
    logic         sel_lane1 = 1'b0, oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_drive, b1_drive, b2_drive;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    logic [W-1:0] m_s1 = '0, m_s2 = '0, m_l2w = '0, m_st1 = '0, m_st2 = '0;
    logic         m_sel = 1'b0, m_da = 1'b0, m_db = 1'b0;

    always #2 clk = ~clk;

    bus_exchanger_n2w #(.W(W)) i_bus_exchanger_n2w (
        .clk(clk), .rst(rst), .a_in(a_in), .a_cap1_n(a_cap1_n), .a_cap2_n(a_cap2_n),
        .b1_in(b1_in), .b2_in(b2_in), .b1_cap_n(b1_cap_n), .b2_cap_n(b2_cap_n),
        .sel_lane1(sel_lane1), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .a_out(a_out), .a_drive(a_drive), .b1_out(b1_out), .b1_drive(b1_drive),
        .b2_out(b2_out), .b2_drive(b2_drive)
    );

    function automatic logic [W-1:0] exp_a_out();
        return m_sel ? m_st1 : m_st2;
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic model_update();
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_l2w = '0; m_st1 = '0; m_st2 = '0;
            m_sel = 1'b0; m_da = 1'b0; m_db = 1'b0;
        end else begin
            if (!a_cap1_n) begin m_s2 = m_s1; m_s1 = a_in; end
            if (!a_cap2_n) m_l2w = a_in;
            if (!b1_cap_n) m_st1 = b1_in;
            if (!b2_cap_n) m_st2 = b2_in;
            m_sel = sel_lane1;
            m_da = !oe_a_n;
            m_db = !oe_b_n;
        end
    endtask

    task automatic compare();
        check("R2 b1_out", b1_out, m_s2);
        check("R3 b2_out", b2_out, m_l2w);
        check("R6 a_out", a_out, exp_a_out());
        check("R8 a_drive", a_drive, m_da);
        check("R9 b1_drive", b1_drive, m_db);
        check("R9 b2_drive", b2_drive, m_db);
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        // R1: reset state
        rst = 1'b1; oe_a_n = 1'b0; oe_b_n = 1'b0;
        tick(); tick();
        check("R1 a_out zero", a_out, 0);
        check("R1 b1_out zero", b1_out, 0);
        check("R1 b2_out zero", b2_out, 0);
        check("R1 drives off", {a_drive, b1_drive, b2_drive}, 0);
        @(negedge clk); rst = 1'b0; oe_a_n = 1'b1; oe_b_n = 1'b1;
        tick();

        // R4: pairing of two words
        a_in = 12'hA5C; a_cap1_n = 1'b0; a_cap2_n = 1'b1;
        tick();
        a_in = 12'h3E1; a_cap1_n = 1'b0; a_cap2_n = 1'b0;
        tick();
        check("R4 first word on lane1", b1_out, 12'hA5C);
        check("R4 second word on lane2", b2_out, 12'h3E1);

        // R5: enables high, a_in ignored
        a_cap1_n = 1'b1; a_cap2_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            a_in = 12'h700 + 12'(i);
            tick();
            check("R5 lane1 held", b1_out, 12'hA5C);
            check("R5 lane2 held", b2_out, 12'h3E1);
        end

        // R7: select switches on the edge
        b1_in = 12'h111; b2_in = 12'h222; b1_cap_n = 1'b0; b2_cap_n = 1'b0; sel_lane1 = 1'b1;
        tick();
        check("R7 lane1 selected", a_out, 12'h111);
        b1_cap_n = 1'b1; b2_cap_n = 1'b1; b1_in = 12'hFFF; b2_in = 12'hEEE; sel_lane1 = 1'b0;
        #1 check("R7 no change before edge", a_out, 12'h111);
        tick();
        check("R7 lane2 after edge", a_out, 12'h222);

        // R8/R9: drive latency and both driving
        oe_a_n = 1'b0; oe_b_n = 1'b0;
        #1 check("R8 a not yet driving", a_drive, 0);
        tick();
        check("R9 both drive", {a_drive, b1_drive, b2_drive}, 3'b111);
        oe_a_n = 1'b1;
        tick();
        check("R8 a released", a_drive, 0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            a_in      = W'($urandom);
            b1_in     = W'($urandom);
            b2_in     = W'($urandom);
            a_cap1_n  = ($urandom % 3) == 0;
            a_cap2_n  = ($urandom % 3) == 0;
            b1_cap_n  = $urandom % 2;
            b2_cap_n  = $urandom % 2;
            sel_lane1 = $urandom % 2;
            oe_a_n    = $urandom % 2;
            oe_b_n    = $urandom % 2;
            tick();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule